// File: doc/BRIEF.md
# Baud Rate Divisor Latch

This block turns the system clock into a baud-rate tick for a serial port. Software programs a 16-bit division ratio as two byte registers over an 8-bit register bus. A down-counter reloads from that ratio and raises `baud_tick` for one system clock every N clocks, where N is the programmed ratio. The serial shifters downstream use this tick as their bit-timing reference.

The two divisor bytes have no addresses of their own. Each shares an offset with another register of the serial port: the low byte with the receive/transmit data register and the high byte with the interrupt-enable register. A divisor-access bit, bit 7 of the line control register, decides which of the two the bus reaches. The data and interrupt-enable registers appear here only as plain storage, so that the sharing can be seen at the bus. Each serial port gets its own copy of the block, placed at its own base address through a parameter. The default base is C0h, and a second port would use D0h.

Writing either divisor byte loads the complete 16-bit value into the counter at once and starts a fresh count. A new rate therefore takes effect without waiting for the old period to finish. Ratios 0 and 1 are not valid. When software writes one of them, the counter runs with a ratio of 2, while the register still reads back what was written.

Top module: `brg_divisor_latch`

## Requirements
- R1: The divisor is {high byte, low byte}. Both bytes are read/write, and a read returns the stored byte, never the live count.
- R2: After reset the low divisor byte reads 02h, the high divisor byte reads 00h, and the line control, data and interrupt-enable registers read 00h.
- R3: With a ratio N from 2 to FFFFh, `baud_tick` is high for exactly one clock every N clocks.
- R4: The block decodes offsets from `BASE_ADDR`: +0 is low divisor or data, +1 is high divisor or interrupt-enable, +3 is line control. While line control bit 7 is 1, offsets +0 and +1 reach the divisor bytes. While it is 0, they reach the data and interrupt-enable registers, and a write there leaves the divisor unchanged.
- R5: A write to either divisor byte loads the full 16-bit value into the counter and restarts the count. This happens even in the middle of a period. The first tick comes N clock edges after the edge that takes the write.
- R6: A stored ratio of 0000h or 0001h makes the counter run as if the ratio were 2. Reads still return the stored value.
- R7: Line control is a full 8-bit read/write register, and only its bit 7 affects this block. Offset +2 and addresses outside the block's four offsets read 00h and ignore writes.
- R8: From reset release, the ticks follow the reset ratio of 2: one tick every second clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W (8) | Register bus address |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Read data for `bus_addr`, combinational |
| baud_tick | output | 1 | One-clock baud pulse, registered |

## Verification
Read data is combinational, so the bench samples it in the same cycle as the address. A register write takes effect at the rising edge that samples `bus_wr`, and is visible on reads from the following half-cycle. After a divisor write taken at edge E, the tick stays low through edges E+1 to E+N-1 and is high after edge E+N. The following ticks come every N edges after that. The bench drives and samples only on falling edges and counts falling edges from the write, so each check lands at exactly the edge its requirement names. Tick spacing is checked as an exact edge count between consecutive ticks: after reset, after a write to the low byte alone, after a write to the high byte alone, after a restart in the middle of a period, and with the clamped ratios.

// File: rtl/brg_pkg.sv
package brg_pkg;

  // Register offsets within the four-address window of one port.
  typedef enum logic [1:0] {
    OFS_DATA = 2'd0,   // data stub, or low divisor byte while access bit is set
    OFS_IER  = 2'd1,   // interrupt-enable stub, or high divisor byte
    OFS_RSV  = 2'd2,   // unused, reads zero
    OFS_LCR  = 2'd3    // line control
  } reg_ofs_e;

  // Position of the divisor-access bit in the line control register.
  localparam int unsigned DIV_ACCESS_BIT = 7;

  // Reset value of the low divisor byte; the high byte resets to zero.
  localparam int unsigned DIV_RESET_LO = 2;

  // Smallest ratio the counter will run with.
  localparam int unsigned DIV_MIN = 2;

endpackage

// File: rtl/brg_rst_sync.sv
module brg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[STAGES-1];

endmodule

// File: rtl/brg_regfile.sv
module brg_regfile
  import brg_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hC0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [2*DATA_W-1:0]   div_q,
  output logic [2*DATA_W-1:0]   div_d,
  output logic                  div_load
);

  localparam int unsigned DIV_W = 2 * DATA_W;

  logic [DATA_W-1:0] lcr_q,  lcr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [DATA_W-1:0] ier_q,  ier_d;
  logic [DATA_W-1:0] dlo_q,  dlo_d;
  logic [DATA_W-1:0] dhi_q,  dhi_d;

  logic     hit;
  logic     div_access;
  reg_ofs_e ofs;

  // Decode
  assign hit        = (bus_addr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);
  assign ofs        = reg_ofs_e'(bus_addr[1:0]);
  assign div_access = lcr_q[DIV_ACCESS_BIT];

  // Next state
  always_comb begin
    lcr_d    = lcr_q;
    data_d   = data_q;
    ier_d    = ier_q;
    dlo_d    = dlo_q;
    dhi_d    = dhi_q;
    div_load = 1'b0;
    if (hit && bus_wr) begin
      unique case (ofs)
        OFS_DATA: begin
          if (div_access) begin
            dlo_d    = bus_wdata;
            div_load = 1'b1;
          end else begin
            data_d = bus_wdata;
          end
        end
        OFS_IER: begin
          if (div_access) begin
            dhi_d    = bus_wdata;
            div_load = 1'b1;
          end else begin
            ier_d = bus_wdata;
          end
        end
        OFS_LCR:  lcr_d = bus_wdata;
        default:  ;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q  <= '0;
      data_q <= '0;
      ier_q  <= '0;
      dlo_q  <= DATA_W'(DIV_RESET_LO);
      dhi_q  <= '0;
    end else begin
      lcr_q  <= lcr_d;
      data_q <= data_d;
      ier_q  <= ier_d;
      dlo_q  <= dlo_d;
      dhi_q  <= dhi_d;
    end
  end

  assign div_q = {dhi_q, dlo_q};
  assign div_d = {dhi_d, dlo_d};

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      unique case (ofs)
        OFS_DATA: bus_rdata = div_access ? dlo_q : data_q;
        OFS_IER:  bus_rdata = div_access ? dhi_q : ier_q;
        OFS_LCR:  bus_rdata = lcr_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/brg_counter.sv
module brg_counter
  import brg_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] div,
  output logic [CNT_W-1:0] cnt,
  output logic             tick
);

  localparam logic [CNT_W-1:0] MIN_DIV = CNT_W'(DIV_MIN);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;

  function automatic logic [CNT_W-1:0] clamp_div(input logic [CNT_W-1:0] v);
    return (v < MIN_DIV) ? MIN_DIV : v;
  endfunction

  // Next state: a load wins over expiry and suppresses the pulse.
  always_comb begin
    cnt_d  = cnt_q - ONE;
    tick_d = 1'b0;
    if (load) begin
      cnt_d = clamp_div(load_val);
    end else if (cnt_q == ONE) begin
      cnt_d  = clamp_div(div);
      tick_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= MIN_DIV;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign cnt  = cnt_q;
  assign tick = tick_q;

endmodule

// File: rtl/brg_divisor_latch.sv
module brg_divisor_latch #(
  parameter int unsigned       ADDR_W     = 8,
  parameter int unsigned       DATA_W     = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 8'hC0,
  parameter int unsigned       RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              baud_tick
);

  localparam int unsigned DIV_W = 2 * DATA_W;

  logic             rst_sync_n;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;
  logic             div_load;
  logic [DIV_W-1:0] cnt_q;

  brg_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  brg_regfile #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .div_q     (div_q),
    .div_d     (div_d),
    .div_load  (div_load)
  );

  brg_counter #(
    .CNT_W (DIV_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (div_load),
    .load_val (div_d),
    .div      (div_q),
    .cnt      (cnt_q),
    .tick     (baud_tick)
  );

endmodule

// File: rtl/brg_divisor_latch_chk.sv
module brg_divisor_latch_chk
  import brg_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hC0
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                div_load,
  input logic [2*DATA_W-1:0] div_q,
  input logic [2*DATA_W-1:0] cnt_q,
  input logic                baud_tick
);

  localparam int unsigned      DIV_W   = 2 * DATA_W;
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(DIV_MIN);

  logic             in_window;
  logic             shared_ofs;
  logic [DIV_W-1:0] run_ratio;

  assign in_window  = (bus_addr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);
  assign shared_ofs = (bus_addr[1] == 1'b0);
  assign run_ratio  = (div_q < MIN_DIV) ? MIN_DIV : div_q;

  // R3: a tick lasts one clock, since no ratio below 2 is ever run
  p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);

  // R3: the count always lies between 1 and the running ratio
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) && (cnt_q <= run_ratio));

  // R3: an expiring count without a load produces a tick
  p_expire_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == DIV_W'(1) && !div_load) |=> baud_tick);

  // R5: a divisor write restarts from the full new ratio, with no pulse
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_load |=> (!baud_tick && cnt_q == run_ratio));

  // R4: with access bit clear, a shared-offset write leaves the divisor alone
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && in_window && shared_ofs && !div_load) |=> $stable(div_q));

  // R7: outside the window the bus reads zero
  p_outside_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_window |-> (bus_rdata == '0));

  // R7: writes outside the window never load the counter
  p_outside_noload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_window |-> !div_load);

endmodule

bind brg_divisor_latch brg_divisor_latch_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .BASE_ADDR (BASE_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .div_load  (div_load),
  .div_q     (div_q),
  .cnt_q     (cnt_q),
  .baud_tick (baud_tick)
);

// File: tb/sim_brg_divisor_latch.sv
`timescale 1ns/1ps
module sim_brg_divisor_latch;

  localparam logic [7:0] BASE  = 8'hC0;
  localparam logic [7:0] A_LO  = BASE + 8'd0;
  localparam logic [7:0] A_HI  = BASE + 8'd1;
  localparam logic [7:0] A_RSV = BASE + 8'd2;
  localparam logic [7:0] A_LCR = BASE + 8'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       baud_tick;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  brg_divisor_latch #(.BASE_ADDR(BASE)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .baud_tick (baud_tick)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  // Waits for a tick, then returns the number of edges to the next one.
  task automatic measure_period(output int p);
    int guard = 0;
    p = 0;
    @(negedge clk);
    while (!baud_tick && guard < 70000) begin
      @(negedge clk);
      guard++;
    end
    do begin
      @(negedge clk);
      p++;
    end while (!baud_tick && p < 70000);
  endtask

  // Call right after bus_write: the current falling edge follows the write edge.
  task automatic expect_restart(input string req, input int n);
    int first = -1;
    check(req, "tick after write edge", int'(baud_tick), 0);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (baud_tick && first < 0) first = k;
    end
    check(req, "edges to first tick", first, n);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    int p;
    check("R2", "tick during reset", int'(baud_tick), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(A_LCR, d);  check("R2", "line control reset", d, 8'h00);
    bus_read(A_LO,  d);  check("R2", "data stub reset", d, 8'h00);
    bus_read(A_HI,  d);  check("R2", "ier stub reset", d, 8'h00);
    measure_period(p);   check("R8", "period after reset", p, 2);
    bus_write(A_LCR, 8'h80);
    bus_read(A_LO,  d);  check("R2", "low divisor reset", d, 8'h02);
    bus_read(A_HI,  d);  check("R2", "high divisor reset", d, 8'h00);
    measure_period(p);   check("R8", "period with access bit set", p, 2);
  endtask

  task automatic t_low_write();
    int p;
    bus_write(A_LO, 8'h05);
    expect_restart("R5", 5);
    measure_period(p); check("R3", "period 5", p, 5);
  endtask

  task automatic t_high_write();
    logic [7:0] d;
    int p;
    bus_write(A_HI, 8'h01);
    expect_restart("R5", 16'h0105);
    measure_period(p); check("R3", "period 0105h", p, 16'h0105);
    bus_read(A_LO, d); check("R1", "low byte kept", d, 8'h05);
    bus_read(A_HI, d); check("R1", "high byte stored", d, 8'h01);
    bus_write(A_HI, 8'h00);
    expect_restart("R5", 5);
  endtask

  task automatic t_mid_restart();
    logic [7:0] d;
    bus_write(A_LO, 8'h14);
    expect_restart("R5", 20);
    repeat (7) @(negedge clk);
    bus_write(A_LO, 8'h06);
    expect_restart("R5", 6);
    repeat (3) @(negedge clk);
    bus_read(A_LO, d); check("R1", "read returns stored not count", d, 8'h06);
  endtask

  task automatic t_clamp();
    logic [7:0] d;
    int p;
    bus_write(A_LO, 8'h00);
    expect_restart("R6", 2);
    measure_period(p); check("R6", "period for ratio 0", p, 2);
    bus_read(A_LO, d); check("R6", "ratio 0 reads back", d, 8'h00);
    bus_write(A_LO, 8'h01);
    measure_period(p); check("R6", "period for ratio 1", p, 2);
    bus_read(A_LO, d); check("R6", "ratio 1 reads back", d, 8'h01);
    bus_write(A_LO, 8'h03);
    measure_period(p); check("R3", "period 3", p, 3);
  endtask

  task automatic t_gate();
    logic [7:0] d;
    int p;
    bus_write(A_LCR, 8'h00);
    bus_write(A_LO, 8'hAA);
    bus_write(A_HI, 8'h55);
    bus_read(A_LO, d);  check("R4", "data stub written", d, 8'hAA);
    bus_read(A_HI, d);  check("R4", "ier stub written", d, 8'h55);
    measure_period(p);  check("R4", "period unchanged by stub writes", p, 3);
    bus_write(A_LCR, 8'h80);
    bus_read(A_LO, d);  check("R4", "low divisor untouched", d, 8'h03);
    bus_read(A_HI, d);  check("R4", "high divisor untouched", d, 8'h00);
    bus_write(A_LCR, 8'h00);
    bus_read(A_LO, d);  check("R4", "data stub kept", d, 8'hAA);
  endtask

  task automatic t_decode();
    logic [7:0] d;
    int p;
    bus_write(A_LCR, 8'h7F);
    bus_read(A_LCR, d); check("R7", "line control 7Fh", d, 8'h7F);
    bus_read(A_LO, d);  check("R7", "bit 7 clear gives data stub", d, 8'hAA);
    bus_write(A_LCR, 8'hFF);
    bus_read(A_LCR, d); check("R7", "line control FFh", d, 8'hFF);
    bus_write(A_RSV, 8'h99);
    bus_read(A_RSV, d); check("R7", "offset 2 reads zero", d, 8'h00);
    bus_write(8'hD0, 8'h09);
    bus_write(8'h40, 8'h09);
    bus_read(8'hD0, d); check("R7", "other base reads zero", d, 8'h00);
    bus_read(A_LO, d);  check("R7", "divisor untouched by outside write", d, 8'h03);
    measure_period(p);  check("R7", "period untouched by outside write", p, 3);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_low_write();
    t_high_write();
    t_mid_restart();
    t_clamp();
    t_gate();
    t_decode();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule